// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block collects one request line per interrupt vector and presents the single winning vector number to the CPU. Arbitration runs in two tiers. Each source carries a software-written level bit (high or low) and an enable bit. Among the eligible requests, any high-level request beats every low-level one. Within a tier, the smallest vector number wins, so vector 0 has the greatest natural weight. Some vector positions have no source attached. They are tied off in hardware and can never be enabled, requested or presented.

The winner is chosen combinationally from the masked request vector and is captured in one register stage before it reaches the CPU-side outputs. The CPU takes the presented vector with an acknowledge strobe and ends its handler with a return strobe. The block keeps a two-deep service state: idle, low service, high service, or high service nested over a low one. A high-level request may preempt low service. On return, the interrupted low service is restored, vector number included. Request flags are never cleared by the block; that is left to the peripherals.

Software configures the block through a write-only port. A one-bit datum is written to a selected field of a selected vector index. The same port also sets the global interrupt enable and the vectored-mode switch. With vectored mode off, every source counts as low level.

Top module: `irq_arb_top`

## Requirements
- R1: After reset, `irqValid`=0, `irqHigh`=0, `irqVec`=0, `svcLevel`=0 (idle) and `svcVec`=0. All enable bits, level bits, global enable and vectored mode are 0.
- R2: Vector i is eligible only while `irqReq[i]`, its enable bit and the global enable are all 1. Register writes use `regSel` 0 for the enable bit of vector `regIdx`, `regSel` 1 for its level bit (1 = high), and `regSel` 2 for control, where `regIdx` 0 is the global enable and `regIdx` 1 is vectored mode. `regData` is the written value.
- R3: Reserved vectors 0x13, 0x28, 0x2B, 0x3C, 0x44, 0x48, 0x49, 0x4A, 0x4B and 0x58 ignore writes to their enable and level bits, and are never presented.
- R4: Among eligible requests of the same effective level, the one with the smallest vector number is presented.
- R5: With vectored mode on, an eligible request whose level bit is 1 is presented with `irqHigh`=1 ahead of every low-level request, whatever their vector numbers.
- R6: With vectored mode off, level bits are ignored: every source competes in one tier by vector number, and `irqHigh` stays 0.
- R7: `irqValid`, `irqVec` and `irqHigh` are registered. They reflect the requests, registers and service state present before the preceding rising clock edge.
- R8: An `irqAck` while `irqValid`=1 loads `svcVec` with `irqVec` and sets `svcLevel` to 2 for a high or 1 for a low winner at the next edge, and `irqValid` is 0 in the cycle after. An `irqAck` while `irqValid`=0 changes nothing.
- R9: During low service (`svcLevel`=1) only high-level requests are presented. During high service (`svcLevel`=2) no request is presented.
- R10: Acknowledging a high request during low service nests it. The following `irqRet` returns to `svcLevel`=1, with `svcVec` restored to the interrupted low vector.
- R11: An `irqRet` in un-nested service returns to idle with `svcVec`=0. `irqRet` is ignored while idle, and in any cycle where an acknowledge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_VEC | Request line per vector, bit i is vector i |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Field select: 0 enable, 1 level, 2 control |
| regIdx | input | VEC_W | Vector index, or control bit index |
| regData | input | 1 | Written bit value |
| irqAck | input | 1 | CPU acknowledge of the presented vector |
| irqRet | input | 1 | CPU return-from-interrupt strobe |
| irqValid | output | 1 | A vector is presented |
| irqVec | output | VEC_W | Presented vector number |
| irqHigh | output | 1 | Presented vector is high level |
| svcLevel | output | 2 | Service state: 0 idle, 1 low, 2 high |
| svcVec | output | VEC_W | Vector currently in service |

## Verification
The bench first raises several requests together with nothing enabled, then with only the enable bits set, then with only the global enable set. This tells apart each term of the eligibility mask. Mixed request sets, first with all sources low and then with a high-numbered source moved to high level, show whether the tie-break follows vector order and whether the level tier overrides it. The same set is replayed with vectored mode off to show that the level bits are ignored. Reserved vectors are enabled and requested next to a real source. Acknowledge and return sequences then cover low service, nesting of high service, restoration on return, a stray acknowledge, a return while idle, and an acknowledge and return in the same cycle. A behavioural model checks every cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int unsigned SEL_EN  = 0;
  localparam int unsigned SEL_LVL = 1;
  localparam int unsigned SEL_CTL = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOW    = 2'd1,
    ST_HIGH   = 2'd2,
    ST_NESTED = 2'd3
  } svcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic allowLow;
    logic allowHigh;
    logic take;
    logic saveLow;
    logic restoreLow;
    logic clearSvc;
  } arbStrobe_t;

  // vector positions with no source attached
  function automatic logic [127:0] rsvDefault();
    logic [127:0] m;
    m = '0;
    m[8'h13] = 1'b1;
    m[8'h28] = 1'b1;
    m[8'h2B] = 1'b1;
    m[8'h3C] = 1'b1;
    m[8'h44] = 1'b1;
    for (int i = 8'h48; i <= 8'h4B; i++) m[i] = 1'b1;
    m[8'h58] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_VEC = 89,
  parameter int unsigned VEC_W = $clog2(NUM_VEC),
  parameter logic [NUM_VEC-1:0] RSV_MASK = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] irqReq,
  input  logic               regWe,
  input  logic [1:0]         regSel,
  input  logic [VEC_W-1:0]   regIdx,
  input  logic               regData,
  input  arbStrobe_t         strobe,
  output logic               pendValid,
  output logic [VEC_W-1:0]   pendVec,
  output logic               pendHigh,
  output logic [VEC_W-1:0]   svcVec
);

  logic [NUM_VEC-1:0] enReg;
  logic [NUM_VEC-1:0] lvlReg;
  logic               globalEn;
  logic               vecMode;

  logic selEn, selLvl, selCtl;
  assign selEn  = regWe && (regSel == 2'(SEL_EN));
  assign selLvl = regWe && (regSel == 2'(SEL_LVL));
  assign selCtl = regWe && (regSel == 2'(SEL_CTL));

  // per-source configuration bits; reserved positions are constants
  for (genvar i = 0; i < NUM_VEC; i++) begin : g_src
    if (RSV_MASK[i]) begin : g_tie
      assign enReg[i]  = 1'b0;
      assign lvlReg[i] = 1'b0;
    end else begin : g_reg
      logic enQ, lvlQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          enQ  <= 1'b0;
          lvlQ <= 1'b0;
        end else if (regIdx == VEC_W'(i)) begin
          if (selEn)  enQ  <= regData;
          if (selLvl) lvlQ <= regData;
        end
      end
      assign enReg[i]  = enQ;
      assign lvlReg[i] = lvlQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      vecMode  <= 1'b0;
    end else if (selCtl) begin
      if (regIdx == VEC_W'(0)) globalEn <= regData;
      if (regIdx == VEC_W'(1)) vecMode  <= regData;
    end
  end

  // masking and tier split
  logic [NUM_VEC-1:0] masked, effHigh, hiCand, loCand;
  assign masked  = irqReq & enReg & {NUM_VEC{globalEn}};
  assign effHigh = lvlReg & {NUM_VEC{vecMode}};
  assign hiCand  = masked & effHigh & {NUM_VEC{strobe.allowHigh}};
  assign loCand  = masked & ~effHigh & {NUM_VEC{strobe.allowLow}};

  // lowest set index, with a found flag on top
  function automatic logic [VEC_W:0] pickLowest(input logic [NUM_VEC-1:0] c);
    logic [VEC_W:0] r;
    r = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (c[i]) r = {1'b1, VEC_W'(i)};
    end
    return r;
  endfunction

  logic [VEC_W:0] hiPick, loPick;
  logic           winValid, winHigh;
  logic [VEC_W-1:0] winVec;

  always_comb begin
    hiPick = pickLowest(hiCand);
    loPick = pickLowest(loCand);
    if (hiPick[VEC_W]) begin
      winValid = 1'b1;
      winHigh  = 1'b1;
      winVec   = hiPick[VEC_W-1:0];
    end else begin
      winValid = loPick[VEC_W];
      winHigh  = 1'b0;
      winVec   = loPick[VEC_W-1:0];
    end
  end

  // presentation register; cleared on accepted acknowledge
  always_ff @(posedge clk) begin
    if (!rstN || strobe.take) begin
      pendValid <= 1'b0;
      pendVec   <= '0;
      pendHigh  <= 1'b0;
    end else begin
      pendValid <= winValid;
      pendVec   <= winValid ? winVec : '0;
      pendHigh  <= winHigh;
    end
  end

  // service vectors: current and the interrupted low one
  logic [VEC_W-1:0] lowVec;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      svcVec <= '0;
      lowVec <= '0;
    end else begin
      if (strobe.saveLow) lowVec <= svcVec;
      if (strobe.take) svcVec <= pendVec;
      else if (strobe.restoreLow) svcVec <= lowVec;
      else if (strobe.clearSvc) svcVec <= '0;
    end
  end

endmodule

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       irqAck,
  input  logic       irqRet,
  input  logic       pendValid,
  input  logic       pendHigh,
  output arbStrobe_t strobe,
  output logic [1:0] svcLevel
);

  svcState_e state, stateNext;
  logic take, pop;

  assign take = irqAck && pendValid;
  assign pop  = irqRet && !take && (state != ST_IDLE);

  always_comb begin
    strobe.allowLow   = (state == ST_IDLE);
    strobe.allowHigh  = (state == ST_IDLE) || (state == ST_LOW);
    strobe.take       = take;
    strobe.saveLow    = take && (state == ST_LOW);
    strobe.restoreLow = pop && (state == ST_NESTED);
    strobe.clearSvc   = pop && ((state == ST_LOW) || (state == ST_HIGH));
  end

  always_comb begin
    stateNext = state;
    if (take) begin
      if (pendHigh) stateNext = (state == ST_LOW) ? ST_NESTED : ST_HIGH;
      else          stateNext = ST_LOW;
    end else if (pop) begin
      stateNext = (state == ST_NESTED) ? ST_LOW : ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    case (state)
      ST_LOW:              svcLevel = 2'd1;
      ST_HIGH, ST_NESTED:  svcLevel = 2'd2;
      default:             svcLevel = 2'd0;
    endcase
  end

endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_VEC = 89,
  parameter int unsigned VEC_W = $clog2(NUM_VEC),
  parameter logic [NUM_VEC-1:0] RSV_MASK = NUM_VEC'(irq_arb_pkg::rsvDefault())
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] irqReq,
  input  logic               regWe,
  input  logic [1:0]         regSel,
  input  logic [VEC_W-1:0]   regIdx,
  input  logic               regData,
  input  logic               irqAck,
  input  logic               irqRet,
  output logic               irqValid,
  output logic [VEC_W-1:0]   irqVec,
  output logic               irqHigh,
  output logic [1:0]         svcLevel,
  output logic [VEC_W-1:0]   svcVec
);

  arbStrobe_t strobe;

  irq_arb_datapath #(
    .NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .RSV_MASK(RSV_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqReq(irqReq),
    .regWe(regWe), .regSel(regSel), .regIdx(regIdx), .regData(regData),
    .strobe(strobe),
    .pendValid(irqValid), .pendVec(irqVec), .pendHigh(irqHigh),
    .svcVec(svcVec)
  );

  irq_arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .irqAck(irqAck), .irqRet(irqRet),
    .pendValid(irqValid), .pendHigh(irqHigh),
    .strobe(strobe), .svcLevel(svcLevel)
  );

endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
  parameter int unsigned NUM_VEC = 89,
  parameter int unsigned VEC_W = $clog2(NUM_VEC),
  parameter logic [NUM_VEC-1:0] RSV_MASK = '0
) (
  input logic             clk,
  input logic             rstN,
  input logic             irqAck,
  input logic             irqRet,
  input logic             irqValid,
  input logic [VEC_W-1:0] irqVec,
  input logic             irqHigh,
  input logic [1:0]       svcLevel,
  input logic [VEC_W-1:0] svcVec
);

  p_no_reserved_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> !RSV_MASK[irqVec]);

  p_ack_latch_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqValid) |=> (svcVec == $past(irqVec)) && (svcLevel != 2'd0) && !irqValid);

  p_stray_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !irqValid && !irqRet) |=> $stable(svcLevel) && $stable(svcVec));

  p_high_silent_r9: assert property (@(posedge clk) disable iff (!rstN)
    (svcLevel == 2'd2) |-> !irqValid);

  p_low_only_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    (svcLevel == 2'd1 && irqValid) |-> irqHigh);

  p_low_ret_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (svcLevel == 2'd1 && irqRet && !(irqAck && irqValid)) |=> (svcLevel == 2'd0) && (svcVec == '0));

  p_idle_ret_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (svcLevel == 2'd0 && irqRet && !(irqAck && irqValid)) |=> (svcLevel == 2'd0));

endmodule

bind irq_arb_top irq_arb_checker #(
  .NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .RSV_MASK(RSV_MASK)
) u_chk (
  .clk(clk), .rstN(rstN), .irqAck(irqAck), .irqRet(irqRet),
  .irqValid(irqValid), .irqVec(irqVec), .irqHigh(irqHigh),
  .svcLevel(svcLevel), .svcVec(svcVec)
);

// File: tb/irq_arb_top_bench.sv
`timescale 1ns/1ps
module irq_arb_top_bench;
  localparam int NUM_VEC = 89;
  localparam int VEC_W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_VEC-1:0] irqReq = '0;
  logic regWe = 1'b0;
  logic [1:0] regSel = '0;
  logic [VEC_W-1:0] regIdx = '0;
  logic regData = 1'b0;
  logic irqAck = 1'b0;
  logic irqRet = 1'b0;
  logic irqValid, irqHigh;
  logic [VEC_W-1:0] irqVec, svcVec;
  logic [1:0] svcLevel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;

  irq_arb_top u_irq_arb_top (
    .clk(clk), .rstN(rstN), .irqReq(irqReq),
    .regWe(regWe), .regSel(regSel), .regIdx(regIdx), .regData(regData),
    .irqAck(irqAck), .irqRet(irqRet),
    .irqValid(irqValid), .irqVec(irqVec), .irqHigh(irqHigh),
    .svcLevel(svcLevel), .svcVec(svcVec)
  );

  // reserved list taken from R3
  function automatic bit isRsv(int i);
    return (i == 'h13) || (i == 'h28) || (i == 'h2B) || (i == 'h3C) ||
           (i == 'h44) || (i >= 'h48 && i <= 'h4B) || (i == 'h58);
  endfunction

  // behavioural reference model
  bit mEn[NUM_VEC];
  bit mLvl[NUM_VEC];
  bit mGlob, mVecMode, mValid, mHigh, mNested;
  int mVec, mState, mSvc, mLowSvc;

  always @(posedge clk) begin
    bit take, ret, found, fHigh;
    int fVec;
    if (!rstN) begin
      foreach (mEn[i]) begin mEn[i] = 0; mLvl[i] = 0; end
      mGlob = 0; mVecMode = 0; mValid = 0; mHigh = 0; mVec = 0;
      mState = 0; mSvc = 0; mLowSvc = 0; mNested = 0;
    end else begin
      take = irqAck && mValid;
      ret = irqRet && !take && (mState != 0);
      found = 0; fHigh = 0; fVec = 0;
      if (mState <= 1)
        for (int i = 0; i < NUM_VEC; i++)
          if (!found && irqReq[i] && mEn[i] && mGlob && !isRsv(i) && mLvl[i] && mVecMode) begin
            found = 1; fHigh = 1; fVec = i;
          end
      if (!found && mState == 0)
        for (int i = 0; i < NUM_VEC; i++)
          if (!found && irqReq[i] && mEn[i] && mGlob && !isRsv(i) && !(mLvl[i] && mVecMode)) begin
            found = 1; fVec = i;
          end
      if (take) begin
        if (mHigh) begin
          mNested = (mState == 1);
          if (mState == 1) mLowSvc = mSvc;
          mState = 2;
        end else mState = 1;
        mSvc = mVec;
      end else if (ret) begin
        if (mState == 2 && mNested) begin mState = 1; mSvc = mLowSvc; mNested = 0; end
        else begin mState = 0; mSvc = 0; end
      end
      if (regWe) begin
        if (regSel == 0 && regIdx < NUM_VEC && !isRsv(regIdx)) mEn[regIdx] = regData;
        if (regSel == 1 && regIdx < NUM_VEC && !isRsv(regIdx)) mLvl[regIdx] = regData;
        if (regSel == 2 && regIdx == 0) mGlob = regData;
        if (regSel == 2 && regIdx == 1) mVecMode = regData;
      end
      if (take) begin mValid = 0; mHigh = 0; mVec = 0; end
      else begin mValid = found; mHigh = fHigh; mVec = fVec; end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (irqValid !== mValid || irqHigh !== mHigh || int'(irqVec) != mVec ||
          int'(svcLevel) != mState || int'(svcVec) != mSvc) begin
        errors++;
        $display("FAIL %s model: got v=%0d h=%0d vec=%0d lvl=%0d svc=%0d exp v=%0d h=%0d vec=%0d lvl=%0d svc=%0d",
                 tag, irqValid, irqHigh, irqVec, svcLevel, svcVec, mValid, mHigh, mVec, mState, mSvc);
      end
    end
  end

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWr(int sel, int idx, bit d);
    regWe = 1; regSel = 2'(sel); regIdx = VEC_W'(idx); regData = d;
    tick(1);
    regWe = 0;
  endtask

  task automatic pulseAck(); irqAck = 1; tick(1); irqAck = 0; endtask
  task automatic pulseRet(); irqRet = 1; tick(1); irqRet = 0; endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(4);
    rstN = 1;
    tick(1);
    tag = "R1";
    chk("R1 irqValid", irqValid, 0);
    chk("R1 svcLevel", svcLevel, 0);
    chk("R1 svcVec", svcVec, 0);

    tag = "R2";
    irqReq[5] = 1; irqReq[10] = 1; irqReq[30] = 1;
    tick(3);
    chk("R2 nothing enabled", irqValid, 0);
    regWr(0, 10, 1); regWr(0, 30, 1);
    tick(3);
    chk("R2 global off", irqValid, 0);
    regWr(2, 0, 1);
    tick(3);
    tag = "R4";
    chk("R4 lowest of 10,30", irqVec, 10);
    regWr(0, 5, 1);
    tick(3);
    chk("R4 lowest of 5,10,30", irqVec, 5);
    tag = "R2";
    regWr(2, 0, 0);
    tick(3);
    chk("R2 global cleared", irqValid, 0);
    regWr(2, 0, 1);

    tag = "R3";
    irqReq = '0; irqReq['h13] = 1; irqReq['h58] = 1; irqReq['h49] = 1;
    regWr(0, 'h13, 1); regWr(0, 'h58, 1); regWr(0, 'h49, 1);
    tick(3);
    chk("R3 reserved silent", irqValid, 0);
    irqReq[30] = 1;
    tick(3);
    chk("R3 real source past reserved", irqVec, 30);

    tag = "R5";
    irqReq = '0; irqReq[5] = 1; irqReq[30] = 1;
    regWr(2, 1, 1); regWr(1, 30, 1);
    tick(3);
    chk("R5 high beats low vec", irqVec, 30);
    chk("R5 high flag", irqHigh, 1);
    irqReq[10] = 1; regWr(1, 10, 1);
    tick(3);
    chk("R5 tie in high tier", irqVec, 10);

    tag = "R6";
    regWr(2, 1, 0);
    tick(3);
    chk("R6 natural order", irqVec, 5);
    chk("R6 no high flag", irqHigh, 0);
    regWr(2, 1, 1);
    tick(3);

    tag = "R7";
    irqReq[10] = 0;
    tick(1);
    chk("R7 one-cycle update", irqVec, 30);

    tag = "R8";
    irqReq = '0; irqReq[5] = 1;
    tick(3);
    pulseAck();
    chk("R8 svcLevel low", svcLevel, 1);
    chk("R8 svcVec", svcVec, 5);
    chk("R8 valid dropped", irqValid, 0);

    tag = "R9";
    tick(3);
    chk("R9 low held in low service", irqValid, 0);
    irqReq[30] = 1;
    tick(3);
    chk("R9 high presented", irqVec, 30);

    tag = "R10";
    pulseAck();
    chk("R10 nested level", svcLevel, 2);
    chk("R10 nested vec", svcVec, 30);
    irqReq[10] = 1;
    tag = "R9";
    tick(3);
    chk("R9 high service silent", irqValid, 0);
    tag = "R10";
    pulseRet();
    chk("R10 restored level", svcLevel, 1);
    chk("R10 restored vec", svcVec, 5);
    tick(3);
    chk("R10 high presented again", irqVec, 10);

    tag = "R11";
    irqReq = '0;
    tick(3);
    pulseRet();
    chk("R11 low return idle", svcLevel, 0);
    chk("R11 svcVec cleared", svcVec, 0);
    pulseRet();
    chk("R11 idle return ignored", svcLevel, 0);
    tag = "R8";
    pulseAck();
    chk("R8 stray ack", svcLevel, 0);

    tag = "R11";
    irqReq[5] = 1;
    tick(3);
    pulseAck();
    irqReq[30] = 1;
    tick(3);
    irqAck = 1; irqRet = 1;
    tick(1);
    irqAck = 0; irqRet = 0;
    chk("R11 ret ignored with ack", svcLevel, 2);
    chk("R11 ack vec", svcVec, 30);
    irqReq = '0;
    pulseRet();
    pulseRet();
    chk("R11 back to idle", svcLevel, 0);
    tick(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule